// File: doc/BRIEF.md
# Reset and Wakeup Cause Recorder

This block remembers why the system most recently came out of reset or out of a low-power state, so that boot software can pick the right recovery path. Five reset event inputs cover the external reset pin, the watchdog, a wakeup from sleep, a wakeup from deep-stop and a software reset. When several of these arrive in the same cycle, a fixed priority picks one. The chosen cause replaces whatever was recorded before. The cause register is read-only.

A second register gathers the wakeup sources that were active when the system returned to normal mode from idle, stop or sleep. The sources are an external interrupt, an RTC alarm, an RTC tick and a battery fault. The battery-fault source counts only under one power configuration code. The bits of this register pile up until software clears them by writing ones. Both registers are 32 bits wide and are reached through a small register bus. The bus has a select, a write flag, a byte offset and read data that is registered.

Top module: `wake_reset_log`

## Requirements
- R1: In the cycle after synchronous reset `rst` is released, the cause register reads 0x0000_0001 and the wakeup register reads 0x0000_0000. `bus_rdata` is 0 while `rst` is held.
- R2: Each cause is recorded as a single bit. Bit 0 is pin reset, bit 2 is watchdog, bit 3 is sleep wakeup, bit 4 is deep-stop wakeup and bit 5 is software reset. When causes coincide, only the highest one is recorded. The order from highest to lowest is pin, watchdog, sleep, deep-stop, software. Bit 1 and bits 31:6 always read 0.
- R3: The cause register changes only on a cycle that carries at least one reset event. Such an event overwrites the earlier contents on the next clock edge, so older causes are not kept.
- R4: A write to offset 0x0 has no effect on the cause register.
- R5: While `wake_evt` is high, each active source sets its wakeup bit on the next edge. Bit 0 is external interrupt, bit 1 is RTC alarm, bit 4 is RTC tick and bit 5 is battery fault. Bits 3:2 and 31:6 read 0.
- R6: Wakeup bits accumulate over several wakeups. Writing to offset 0x4 clears every bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R7: If a set and a write-1 clear hit the same wakeup bit in the same cycle, the bit ends up set.
- R8: The battery-fault bit is set only while `pwr_cfg` equals 2'b01. For the codes 2'b00, 2'b10 and 2'b11 it is left unchanged.
- R9: A read strobe (`bus_sel`=1, `bus_wr`=0) returns the register contents from the strobe cycle on `bus_rdata` one cycle later. Offsets other than 0x0 and 0x4 read as 0. `bus_rdata` holds its value between read strobes.
- R10: Wakeup sources that are active while `wake_evt` is low do not change the wakeup register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_evt | input | 1 | External reset pin event |
| wdog_evt | input | 1 | Watchdog reset event |
| sleep_wake_evt | input | 1 | Reset by wakeup from sleep |
| dstop_wake_evt | input | 1 | Reset by wakeup from deep-stop |
| soft_rst_evt | input | 1 | Software reset event |
| wake_evt | input | 1 | Return to normal mode from idle, stop or sleep |
| src_eint | input | 1 | External interrupt wakeup source |
| src_alarm | input | 1 | RTC alarm wakeup source |
| src_tick | input | 1 | RTC tick wakeup source |
| src_batt | input | 1 | Battery fault wakeup source |
| pwr_cfg | input | 2 | Power configuration; 2'b01 enables battery-fault capture |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data (write-1-to-clear mask at 0x4) |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The assertions assume that every input is a defined 0 or 1 on each clock edge once reset is released. They also assume that reset events may be levels held for many cycles, because the block treats every high cycle as a fresh event. No timing relation is assumed between reset events, wakeups and bus accesses. The stimulus therefore changes inputs only on falling edges and holds them for whole cycles. It deliberately overlaps events, wakeups, clears and reads in the same cycle, so the properties are exercised exactly at those collisions.

// File: rtl/rwlog_pkg.sv
package rwlog_pkg;
  localparam int NUM_CAUSE = 5;
  localparam int NUM_WSRC  = 4;
  localparam logic [1:0] BATT_CFG = 2'b01;

  // Bit positions of the causes, listed from highest to lowest priority.
  function automatic int cause_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      default: return 5;
    endcase
  endfunction

  // Bit positions of the wakeup sources: eint, alarm, tick, batt.
  function automatic int wsrc_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/cause_arbiter.sv
module cause_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] evt,
  output logic [N-1:0] win,
  output logic         any
);
  // Index 0 has the highest priority.
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign win[i] = evt[i];
    end else begin : g_low
      assign win[i] = evt[i] & ~(|evt[i-1:0]);
    end
  end
  assign any = |evt;
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rwlog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CAUSE-1:0] win,
  input  logic                 any,
  output logic [DATA_W-1:0]    cause_q
);
  logic [DATA_W-1:0] next_val;

  always_comb begin
    next_val = '0;
    for (int i = 0; i < NUM_CAUSE; i++) begin
      next_val[cause_pos(i)] = win[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= DATA_W'(1);
    end else if (any) begin
      cause_q <= next_val;
    end
  end
endmodule

// File: rtl/wake_status_reg.sv
module wake_status_reg
  import rwlog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wake_evt,
  input  logic [NUM_WSRC-1:0] src,
  input  logic [1:0]          pwr_cfg,
  input  logic                clr_en,
  input  logic [DATA_W-1:0]   clr_mask,
  output logic [DATA_W-1:0]   wake_q
);
  logic [NUM_WSRC-1:0] gated;
  logic [DATA_W-1:0]   set_vec;
  logic [DATA_W-1:0]   clr_vec;

  for (genvar i = 0; i < NUM_WSRC; i++) begin : g_gate
    if (i == NUM_WSRC - 1) begin : g_batt
      assign gated[i] = wake_evt & src[i] & (pwr_cfg == BATT_CFG);
    end else begin : g_plain
      assign gated[i] = wake_evt & src[i];
    end
  end

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_WSRC; i++) begin
      set_vec[wsrc_pos(i)] = gated[i];
    end
    clr_vec = clr_en ? clr_mask : '0;
  end

  // A set wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q <= '0;
    end else begin
      wake_q <= (wake_q & ~clr_vec) | set_vec;
    end
  end
endmodule

// File: rtl/bus_regs.sv
module bus_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] cause_q,
  input  logic [DATA_W-1:0] wake_q,
  output logic              clr_en,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] OFF_CAUSE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_WAKE  = ADDR_W'(4);

  logic rd_en;
  logic [DATA_W-1:0] rd_mux;

  assign rd_en  = bus_sel & ~bus_wr;
  assign clr_en = bus_sel & bus_wr & (bus_addr == OFF_WAKE);

  always_comb begin
    if (bus_addr == OFF_CAUSE)     rd_mux = cause_q;
    else if (bus_addr == OFF_WAKE) rd_mux = wake_q;
    else                           rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/wake_reset_log.sv
module wake_reset_log
  import rwlog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_pin_evt,
  input  logic              wdog_evt,
  input  logic              sleep_wake_evt,
  input  logic              dstop_wake_evt,
  input  logic              soft_rst_evt,
  input  logic              wake_evt,
  input  logic              src_eint,
  input  logic              src_alarm,
  input  logic              src_tick,
  input  logic              src_batt,
  input  logic [1:0]        pwr_cfg,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [NUM_CAUSE-1:0] evt_vec;
  logic [NUM_CAUSE-1:0] win_vec;
  logic                 evt_any;
  logic [DATA_W-1:0]    cause_q;
  logic [DATA_W-1:0]    wake_q;
  logic                 clr_en;

  assign evt_vec = {soft_rst_evt, dstop_wake_evt, sleep_wake_evt, wdog_evt, rst_pin_evt};

  cause_arbiter #(.N(NUM_CAUSE)) u_arb (
    .evt (evt_vec),
    .win (win_vec),
    .any (evt_any)
  );

  reset_cause_reg #(.DATA_W(DATA_W)) u_cause (
    .clk     (clk),
    .rst     (rst),
    .win     (win_vec),
    .any     (evt_any),
    .cause_q (cause_q)
  );

  wake_status_reg #(.DATA_W(DATA_W)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .wake_evt (wake_evt),
    .src      ({src_batt, src_tick, src_alarm, src_eint}),
    .pwr_cfg  (pwr_cfg),
    .clr_en   (clr_en),
    .clr_mask (bus_wdata),
    .wake_q   (wake_q)
  );

  bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .cause_q   (cause_q),
    .wake_q    (wake_q),
    .clr_en    (clr_en),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/wake_reset_log_chk.sv
module wake_reset_log_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rst_pin_evt,
  input logic              wdog_evt,
  input logic              sleep_wake_evt,
  input logic              dstop_wake_evt,
  input logic              soft_rst_evt,
  input logic              wake_evt,
  input logic              src_eint,
  input logic              src_batt,
  input logic [1:0]        pwr_cfg,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] cause_q,
  input logic [DATA_W-1:0] wake_q
);
  logic any_evt;
  assign any_evt = rst_pin_evt | wdog_evt | sleep_wake_evt | dstop_wake_evt | soft_rst_evt;

  p_one_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(cause_q) == 1 && cause_q[1] == 1'b0);

  p_pin_top_r2: assert property (@(posedge clk) disable iff (rst)
    rst_pin_evt |=> cause_q == DATA_W'(1));

  p_cause_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !any_evt |=> $stable(cause_q));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (wake_evt && src_eint) |=> wake_q[0]);

  p_batt_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!wake_q[5] && pwr_cfg != 2'b01) |=> !wake_q[5]);

  p_quiet_src_r10: assert property (@(posedge clk) disable iff (rst)
    !wake_evt |=> (wake_q & ~$past(wake_q)) == '0);

  p_rd_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(0)) |=> bus_rdata == $past(cause_q));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    wake_q[3:2] == 2'b00 && wake_q[DATA_W-1:6] == '0);
endmodule

bind wake_reset_log wake_reset_log_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .rst_pin_evt    (rst_pin_evt),
  .wdog_evt       (wdog_evt),
  .sleep_wake_evt (sleep_wake_evt),
  .dstop_wake_evt (dstop_wake_evt),
  .soft_rst_evt   (soft_rst_evt),
  .wake_evt       (wake_evt),
  .src_eint       (src_eint),
  .src_batt       (src_batt),
  .pwr_cfg        (pwr_cfg),
  .bus_sel        (bus_sel),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .bus_rdata      (bus_rdata),
  .cause_q        (cause_q),
  .wake_q         (wake_q)
);

// File: tb/wake_reset_log_test.sv
module wake_reset_log_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int WDOG_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] evts = '0;  // pin, wdog, sleep, dstop, soft (index 0 first)
  logic wake_evt = 1'b0;
  logic [3:0] srcs = '0;  // eint, alarm, tick, batt
  logic [1:0] pwr_cfg = 2'b00;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";
  logic [DW-1:0] m_cause, m_wake, m_rdata;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_reset_log #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst),
    .rst_pin_evt(evts[0]), .wdog_evt(evts[1]), .sleep_wake_evt(evts[2]),
    .dstop_wake_evt(evts[3]), .soft_rst_evt(evts[4]),
    .wake_evt(wake_evt), .src_eint(srcs[0]), .src_alarm(srcs[1]),
    .src_tick(srcs[2]), .src_batt(srcs[3]), .pwr_cfg(pwr_cfg),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Behavioural reference model, advanced on every rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_cause = 32'h1; m_wake = '0; m_rdata = '0;
    end else begin
      if (bus_sel && !bus_wr)
        m_rdata = (bus_addr == 0) ? m_cause : (bus_addr == 4) ? m_wake : '0;
      if (evts[0])      m_cause = 32'h01;
      else if (evts[1]) m_cause = 32'h04;
      else if (evts[2]) m_cause = 32'h08;
      else if (evts[3]) m_cause = 32'h10;
      else if (evts[4]) m_cause = 32'h20;
      if (bus_sel && bus_wr && bus_addr == 4) m_wake = m_wake & ~bus_wdata;
      if (wake_evt) begin
        if (srcs[0]) m_wake[0] = 1'b1;
        if (srcs[1]) m_wake[1] = 1'b1;
        if (srcs[2]) m_wake[4] = 1'b1;
        if (srcs[3] && pwr_cfg == 2'b01) m_wake[5] = 1'b1;
      end
    end
  end

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (cycles > 1) begin
      checks++;
      if (bus_rdata !== m_rdata) begin
        failures++;
        $display("FAIL %s model compare: actual=%h expected=%h", cur_req, bus_rdata, m_rdata);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WDOG_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evts = '0; wake_evt = 0; srcs = '0; bus_sel = 0; bus_wr = 0;
    end
  endtask

  task automatic fire(input logic [4:0] e);
    @(negedge clk);
    evts = e; wake_evt = 0; srcs = '0; bus_sel = 0;
    @(negedge clk);
    evts = '0;
  endtask

  task automatic wake(input logic [3:0] s);
    @(negedge clk);
    wake_evt = 1; srcs = s; bus_sel = 0;
    @(negedge clk);
    wake_evt = 0; srcs = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic expect_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s read @%0h: actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  function automatic logic [DW-1:0] win_of(input logic [4:0] e);
    if (e[0]) return 32'h01;
    if (e[1]) return 32'h04;
    if (e[2]) return 32'h08;
    if (e[3]) return 32'h10;
    return 32'h20;
  endfunction

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (bus_rdata !== '0) begin
      failures++;
      $display("FAIL R1 rdata in reset: actual=%h expected=0", bus_rdata);
    end
    rst = 0;
    expect_read(0, 32'h1, "R1");
    expect_read(4, 32'h0, "R1");

    // R2: every pair of simultaneous causes, then all five
    cur_req = "R2";
    for (int i = 0; i < 5; i++) begin
      for (int j = i + 1; j < 5; j++) begin
        logic [4:0] e;
        e = 5'(1 << i) | 5'(1 << j);
        fire(e);
        expect_read(0, win_of(e), "R2");
      end
    end
    fire(5'b11111);
    expect_read(0, 32'h01, "R2");

    // R3: replacement, and holding without events
    cur_req = "R3";
    fire(5'b00010);
    fire(5'b10000);
    expect_read(0, 32'h20, "R3");
    idle(5);
    expect_read(0, 32'h20, "R3");
    fire(5'b01000);
    expect_read(0, 32'h10, "R3");

    // R4: writes to the cause register are ignored
    cur_req = "R4";
    wr(0, 32'hFFFF_FFFF);
    expect_read(0, 32'h10, "R4");
    wr(0, 32'h0);
    expect_read(0, 32'h10, "R4");

    // R10: sources without wake_evt
    cur_req = "R10";
    pwr_cfg = 2'b01;
    @(negedge clk); srcs = 4'hF;
    idle(1);
    expect_read(4, 32'h0, "R10");

    // R5: each source sets its own bit
    cur_req = "R5";
    wake(4'b0001); expect_read(4, 32'h01, "R5");
    wr(4, 32'hFFFF_FFFF);
    wake(4'b0010); expect_read(4, 32'h02, "R5");
    wr(4, 32'hFFFF_FFFF);
    wake(4'b0100); expect_read(4, 32'h10, "R5");
    wr(4, 32'hFFFF_FFFF);
    wake(4'b1000); expect_read(4, 32'h20, "R5");
    wr(4, 32'hFFFF_FFFF);
    expect_read(4, 32'h0, "R5");

    // R6: accumulation and write-1-to-clear
    cur_req = "R6";
    wake(4'b0001);
    wake(4'b0100);
    expect_read(4, 32'h11, "R6");
    wr(4, 32'h0);
    expect_read(4, 32'h11, "R6");
    wr(4, 32'h01);
    expect_read(4, 32'h10, "R6");
    wr(0, 32'hFFFF_FFFF);
    expect_read(4, 32'h10, "R6");

    // R7: set and clear in the same cycle
    cur_req = "R7";
    wr(4, 32'hFFFF_FFFF);
    wake(4'b0001);
    @(negedge clk);
    wake_evt = 1; srcs = 4'b0001; bus_sel = 1; bus_wr = 1; bus_addr = 4; bus_wdata = 32'h1;
    @(negedge clk);
    wake_evt = 0; srcs = '0; bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    expect_read(4, 32'h01, "R7");

    // R8: battery fault gated by the power configuration
    cur_req = "R8";
    wr(4, 32'hFFFF_FFFF);
    for (int c = 0; c < 4; c++) begin
      pwr_cfg = 2'(c);
      wake(4'b1000);
      expect_read(4, (c == 1) ? 32'h20 : 32'h0, "R8");
      wr(4, 32'hFFFF_FFFF);
    end

    // R9: unmapped offsets, latency and hold
    cur_req = "R9";
    expect_read(8, 32'h0, "R9");
    expect_read(0, 32'h10, "R9");
    idle(3);
    checks++;
    if (bus_rdata !== 32'h10) begin
      failures++;
      $display("FAIL R9 rdata hold: actual=%h expected=%h", bus_rdata, 32'h10);
    end
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 0; evts = 5'b00001;
    @(negedge clk);
    bus_sel = 0; evts = '0;
    checks++;
    if (bus_rdata !== 32'h10) begin
      failures++;
      $display("FAIL R9 pre-update read: actual=%h expected=%h", bus_rdata, 32'h10);
    end
    expect_read(0, 32'h01, "R9");

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule